// File: doc/BRIEF.md
# Table-Interpolated Reciprocal Divider

This block divides a 17-bit unsigned numerator by a 17-bit unsigned denominator and returns a 16-bit quotient. It is fully pipelined: a new operand pair may be presented on every clock, and each result appears a fixed six cycles later with its own valid flag. Results leave in the order the operands arrived.

The divider has no subtract loop. Both operands are first shifted left until their top bit is set. The ten bits below the leading one of the shifted denominator select an entry in a reciprocal table and in a slope table. The six remaining low bits scale the slope to form a correction, and that correction is subtracted from the table reciprocal. The refined reciprocal is multiplied by the shifted numerator. The product is then shifted right by an amount set by the two normalizing shifts and rounded to the nearest integer.

Both tables are computed by constant functions when the design is elaborated. A zero denominator raises a flag next to the valid bit. Quotients that do not fit in 16 bits saturate.

Top module: `recip_interp_div`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one result, with `out_valid` high exactly 6 clock cycles later. Results come out in issue order, and `out_valid` is low in every other cycle.
- R2: For a nonzero denominator whose exact quotient is below 65536, `out_q` equals either floor(num/den) or floor(num/den)+1.
- R3: When num/den is 65536 or more (possible only with den = 1 and num ≥ 65536), `out_q` is 65535 (all ones) and `out_dz` is 0.
- R4: A zero denominator gives `out_dz` = 1 and `out_q` = 65535 (all ones) on the result cycle. `out_dz` is never high unless `out_valid` is high.
- R5: A zero numerator with a nonzero denominator gives `out_q` = 0.
- R6: When the denominator is a power of two, 2^k, `out_q` is num/2^k rounded to nearest with halves rounded up, that is floor((num + 2^k/2) / 2^k). For den = 1 this is num itself.
- R7: While `rst_n` is low, and for the first 6 cycles after it is released, `out_valid` and `out_dz` are 0. During reset `out_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_num | input | 17 | Unsigned numerator |
| in_den | input | 17 | Unsigned denominator |
| out_valid | output | 1 | Result present this cycle |
| out_dz | output | 1 | Denominator of this result was zero |
| out_q | output | 16 | Rounded, saturated quotient |

## Verification
Directed pairs cover specific regions of the table. Powers of two hit entry zero with no correction and must give the exact rounded value. Small odd divisors such as 3 land on mid-table entries with zero interpolation. Large arbitrary divisors exercise the slope correction. Full-scale and zero operands touch the saturation, zero-numerator and divide-by-zero paths. A long stream of back-to-back random pairs, with magnitudes spread by random shifts, varies both normalizing shifts on every cycle. This shows whether the shift amounts, numerator and flags stay aligned with their own operation through the pipeline.

// File: rtl/divr_pkg.sv
// Package: shared widths, derived constants and the constant functions that
// build the reciprocal and slope tables at elaboration.
// Assumes the denominator is normalized so its top bit is one, i.e. the
// mantissa m = den_norm / 2**(DEN_W-1) lies in [1,2).
package divr_pkg;
    parameter int NUM_W      = 17;  // numerator width
    parameter int DEN_W      = 17;  // denominator width
    parameter int Q_W        = 16;  // quotient width
    parameter int ADDR_W     = 10;  // table index bits taken below the leading one
    parameter int TAB_W      = 18;  // table entry width
    parameter int SLOPE_FRAC = 10;  // extra fraction bits kept in slope entries
    parameter int LAT        = 6;   // pipeline depth, input to output

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int FRAC_W   = DEN_W - 1 - ADDR_W;       // interpolation bits
    localparam int RSCALE   = TAB_W - 1;                // reciprocal = 2**RSCALE / m
    localparam int CORR_W   = FRAC_W + TAB_W;           // frac * slope
    localparam int CORR_SH  = FRAC_W + SLOPE_FRAC;      // correction scaling
    localparam int PROD_W   = NUM_W + TAB_W;            // numerator * reciprocal
    localparam int NLZ_W    = $clog2(NUM_W + 1);
    localparam int DLZ_W    = $clog2(DEN_W + 1);
    localparam int SH_BASE  = RSCALE + DEN_W - 1;       // right shift with no normalization
    localparam int SH_W     = $clog2(SH_BASE + NUM_W + 1);
    localparam logic [Q_W-1:0] Q_MAX = '1;

    // Per-stage control carried alongside the data.
    typedef struct packed {
        logic vld;
        logic dz;
    } ctl_t;

    // Base reciprocal at table point a: round(2**RSCALE * DEPTH / (DEPTH + a)).
    function automatic logic [TAB_W-1:0] recip_base(input int a);
        logic [63:0] num2;
        logic [63:0] q2;
        num2 = 64'd1 << (RSCALE + ADDR_W + 1);
        q2   = num2 / 64'(DEPTH + a);
        return TAB_W'((q2 + 64'd1) >> 1);
    endfunction

    // Magnitude of the reciprocal drop over one table step, with SLOPE_FRAC extra bits.
    function automatic logic [TAB_W-1:0] recip_slope(input int a);
        logic [63:0] num2;
        num2 = 64'd1 << (RSCALE + SLOPE_FRAC + ADDR_W);
        return TAB_W'(num2 / 64'(DEPTH + a) - num2 / 64'(DEPTH + a + 1));
    endfunction
endpackage

// File: rtl/divr_norm.sv
// Leading-zero normalizer: shifts the operand left until its top bit is set
// and reports the shift. A zero input reports W and yields zero.
// Purely combinational; the caller registers the outputs.
module divr_norm #(
    parameter int W  = 17,
    parameter int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [W-1:0]  norm,
    output logic [LW-1:0] lz
);
    // Count leading zeros: the highest set bit wins because it is visited last.
    always_comb begin
        lz = LW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) lz = LW'(W - 1 - i);
        end
    end

    // Apply the shift.
    assign norm = val << lz;
endmodule

// File: rtl/divr_rom.sv
// Reciprocal and slope tables with a registered read: the outputs for
// address A appear one clock after A is presented. Contents are constants
// produced by the package functions; there is no writable storage.
module divr_rom
    import divr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [TAB_W-1:0]  base,
    output logic [TAB_W-1:0]  slope
);
    logic [TAB_W-1:0] base_rom  [DEPTH];
    logic [TAB_W-1:0] slope_rom [DEPTH];

    // One constant entry per table point.
    for (genvar a = 0; a < DEPTH; a++) begin : g_ent
        localparam logic [TAB_W-1:0] B_VAL = recip_base(a);
        localparam logic [TAB_W-1:0] S_VAL = recip_slope(a);
        assign base_rom[a]  = B_VAL;
        assign slope_rom[a] = S_VAL;
    end

    // Registered lookup of both tables with a shared address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            slope <= '0;
        end else begin
            base  <= base_rom[addr];
            slope <= slope_rom[addr];
        end
    end
endmodule

// File: rtl/recip_interp_div.sv
// Pipelined unsigned divider built from a table reciprocal refined by
// linear interpolation, one multiply by the numerator and a rounding shift.
// Stages: 1 normalize, 2 table read, 3 slope*frac, 4 refined reciprocal,
// 5 numerator*reciprocal, 6 round/saturate. One operation per clock.
// Assumes the package defaults; the quotient is within one of the floor.
module recip_interp_div
    import divr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [NUM_W-1:0] in_num,
    input  logic [DEN_W-1:0] in_den,
    output logic             out_valid,
    output logic             out_dz,
    output logic [Q_W-1:0]   out_q
);
    // Normalizer outputs.
    logic [NUM_W-1:0] num_n;
    logic [NLZ_W-1:0] num_lz;
    logic [DEN_W-1:0] den_n;
    logic [DLZ_W-1:0] den_lz;

    divr_norm #(.W(NUM_W), .LW(NLZ_W)) u_norm_num (.val(in_num), .norm(num_n), .lz(num_lz));
    divr_norm #(.W(DEN_W), .LW(DLZ_W)) u_norm_den (.val(in_den), .norm(den_n), .lz(den_lz));

    // Stage registers.
    ctl_t              s1_c, s2_c, s3_c, s4_c, s5_c;
    logic [NUM_W-1:0]  s1_nn, s2_nn, s3_nn, s4_nn;
    logic [DEN_W-2:0]  s1_dm;
    logic [NLZ_W-1:0]  s1_ln;
    logic [DLZ_W-1:0]  s1_ld;
    logic [SH_W-1:0]   s2_sh, s3_sh, s4_sh, s5_sh;
    logic [FRAC_W-1:0] s2_frac;
    logic [TAB_W-1:0]  s3_base, s4_rc;
    logic [CORR_W-1:0] s3_corr;
    logic [PROD_W-1:0] s5_prod;
    logic [TAB_W-1:0]  rom_base, rom_slope;

    // Stage 1: register normalized operands; zero denominator has no leading one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_c  <= '0;
            s1_nn <= '0;
            s1_dm <= '0;
            s1_ln <= '0;
            s1_ld <= '0;
        end else begin
            s1_c.vld <= in_valid;
            s1_c.dz  <= in_valid & ~den_n[DEN_W-1];
            s1_nn    <= num_n;
            s1_dm    <= den_n[DEN_W-2:0];
            s1_ln    <= num_lz;
            s1_ld    <= den_lz;
        end
    end

    // Stage 2: tables are read in divr_rom; the other operand data is carried alongside.
    divr_rom u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (s1_dm[DEN_W-2 -: ADDR_W]),
        .base  (rom_base),
        .slope (rom_slope)
    );

    // Stage 2: total right shift and the interpolation fraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_c    <= '0;
            s2_nn   <= '0;
            s2_sh   <= '0;
            s2_frac <= '0;
        end else begin
            s2_c    <= s1_c;
            s2_nn   <= s1_nn;
            s2_sh   <= SH_W'(SH_BASE) + SH_W'(s1_ln) - SH_W'(s1_ld);
            s2_frac <= s1_dm[FRAC_W-1:0];
        end
    end

    // Stage 3: slope scaled by the low denominator bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_c    <= '0;
            s3_nn   <= '0;
            s3_sh   <= '0;
            s3_base <= '0;
            s3_corr <= '0;
        end else begin
            s3_c    <= s2_c;
            s3_nn   <= s2_nn;
            s3_sh   <= s2_sh;
            s3_base <= rom_base;
            s3_corr <= CORR_W'(s2_frac) * CORR_W'(rom_slope);
        end
    end

    // Stage 4: refined reciprocal = base minus the rounded correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s4_c  <= '0;
            s4_nn <= '0;
            s4_sh <= '0;
            s4_rc <= '0;
        end else begin
            s4_c  <= s3_c;
            s4_nn <= s3_nn;
            s4_sh <= s3_sh;
            s4_rc <= s3_base - TAB_W'((s3_corr + CORR_W'(1 << (CORR_SH - 1))) >> CORR_SH);
        end
    end

    // Stage 5: numerator times reciprocal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s5_c    <= '0;
            s5_sh   <= '0;
            s5_prod <= '0;
        end else begin
            s5_c    <= s4_c;
            s5_sh   <= s4_sh;
            s5_prod <= PROD_W'(s4_nn) * PROD_W'(s4_rc);
        end
    end

    // Stage 6 arithmetic: round-to-nearest shift back to integer scale.
    logic [63:0] rnd;
    always_comb begin
        rnd = (64'(s5_prod) + (64'd1 << (s5_sh - SH_W'(1)))) >> s5_sh;
    end

    // Stage 6 register: saturate, force all ones on divide by zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dz    <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= s5_c.vld;
            out_dz    <= s5_c.dz;
            if (s5_c.dz || rnd > 64'(Q_MAX)) out_q <= Q_MAX;
            else                             out_q <= rnd[Q_W-1:0];
        end
    end
endmodule

// File: rtl/recip_interp_div_chk.sv
// Checker for recip_interp_div: latency, reset quiet period, divide-by-zero
// flag and zero-numerator behaviour. Bound to every instance of the top.
module recip_interp_div_chk
    import divr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [NUM_W-1:0] in_num,
    input logic [DEN_W-1:0] in_den,
    input logic             out_valid,
    input logic             out_dz,
    input logic [Q_W-1:0]   out_q
);
    localparam int AGE_W = $clog2(LAT + 1);
    logic [AGE_W-1:0] age;

    // Cycles since reset release, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                  age <= '0;
        else if (age != AGE_W'(LAT)) age <= age + AGE_W'(1);
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_W'(LAT)) |-> (out_valid == $past(in_valid, LAT))); // R1
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (age != AGE_W'(LAT)) |-> (!out_valid && !out_dz)); // R7
    AST_DZ_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_dz |-> out_valid); // R4
    AST_DZ_FORCES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dz) |-> (out_q == '1)); // R4
    AST_DZ_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (age == AGE_W'(LAT)) |-> (out_dz == $past(in_valid && in_den == '0, LAT))); // R4
    AST_ZERO_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == AGE_W'(LAT)) && $past(in_valid && in_num == '0 && in_den != '0, LAT))
        |-> (out_q == '0)); // R5
endmodule

bind recip_interp_div recip_interp_div_chk u_chk (.*);

// File: tb/test_recip_interp_div.sv
// Scoreboard bench: the driver queues each issued pair with its issue cycle,
// the monitor pops on every valid result and checks timing and value.
module test_recip_interp_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [16:0] in_num = '0;
    logic [16:0] in_den = '0;
    logic        out_valid;
    logic        out_dz;
    logic [15:0] out_q;

    int total = 0;
    int bad = 0;
    longint cyc = 0;
    bit done = 1'b0;

    typedef struct {
        longint n;
        longint d;
        longint t;
    } item_t;
    item_t sb[$];

    recip_interp_div i_recip_interp_div (.*);

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic issue(input longint n, input longint d);
        item_t it;
        in_valid = 1'b1;
        in_num   = 17'(n);
        in_den   = 17'(d);
        it.n = n; it.d = d; it.t = cyc;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        in_valid = 1'b0;
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: compare each result with the oldest outstanding item.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                item_t it;
                longint fl, lo, hi;
                it = sb.pop_front();
                check(cyc - it.t == 6, "R1 latency", cyc - it.t, 6);
                if (it.d == 0) begin
                    check(out_dz == 1'b1, "R4 dz flag", out_dz, 1);
                    check(out_q == 16'hFFFF, "R4 quotient", out_q, 65535);
                end else begin
                    check(out_dz == 1'b0, "R4 dz clear", out_dz, 0);
                    fl = it.n / it.d;
                    if (it.n == 0) begin
                        check(out_q == 0, "R5 zero numerator", out_q, 0);
                    end else if (fl >= 65536) begin
                        check(out_q == 16'hFFFF, "R3 saturation", out_q, 65535);
                    end else if ((it.d & (it.d - 1)) == 0) begin
                        lo = (it.n + it.d / 2) / it.d;
                        if (lo > 65535) lo = 65535;
                        check(longint'(out_q) == lo, "R6 power of two", out_q, lo);
                    end else begin
                        lo = fl;
                        hi = (fl + 1 > 65535) ? 65535 : fl + 1;
                        check(longint'(out_q) >= lo && longint'(out_q) <= hi,
                              "R2 quotient", out_q, lo);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        // R7: outputs quiet during reset.
        check(out_valid == 1'b0, "R7 reset valid", out_valid, 0);
        check(out_dz == 1'b0, "R7 reset dz", out_dz, 0);
        check(out_q == 16'd0, "R7 reset q", out_q, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: idle pipeline after release.
        repeat (6) begin
            check(out_valid == 1'b0, "R7 post-reset valid", out_valid, 0);
            @(negedge clk);
        end

        // Directed corners, back to back.
        issue(0, 5);            // R5
        issue(100, 0);          // R4
        issue(0, 0);            // R4
        issue(131071, 1);       // R3
        issue(65536, 1);        // R3
        issue(65535, 1);        // R6
        issue(131071, 2);       // R6
        issue(1000, 8);         // R6
        issue(12345, 64);       // R6
        issue(131071, 3);       // R2
        issue(131071, 131071);  // R2
        issue(1, 131071);       // R2
        issue(77777, 333);      // R2
        issue(99999, 1023);     // R2
        issue(131071, 65537);   // R2
        idle(3);

        // Random stream with spread magnitudes and occasional gaps.
        for (int i = 0; i < 3000; i++) begin
            longint n, d;
            n = longint'($urandom_range(0, 131071) >> $urandom_range(0, 16));
            d = longint'($urandom_range(0, 131071) >> $urandom_range(0, 16));
            issue(n, d);
            if ($urandom_range(0, 15) == 0) idle(1);
        end
        idle(10);

        // R1: every issued pair produced exactly one result.
        check(sb.size() == 0, "R1 outstanding results", sb.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule